// File: doc/BRIEF.md
# Chain Device Addressing Registers

This block holds two 16-bit registers for one device in a daisy chain of identical devices. The page address gives the device its own identity in the chain. The device-select value names the device that host commands are aimed at. A device is the target of host commands when the two registers hold the same value. The device-select value with every bit set addresses all devices at once. While that broadcast value is in place, data reads are held off, so that several devices never drive the shared bus together.

A register is written in two steps. A select strobe first picks the register. The next command-write cycle then carries the 16-bit value. Page-address loads are gated by two conditions: the full-flag function must be enabled, and it must be this device's turn in the chain. The all-ones value is never taken as a page address. An attempt to load it raises a one-cycle error pulse. A software reset cancels a write that is armed but not yet done. It leaves both registers as they are. Only a hardware reset clears them.

Top module: `chain_sel_regs`

## Requirements
- R1: Hardware reset (rst_n low) clears page_addr and dev_sel to 0x0000 and leaves no write armed. Right after reset, selected is 1, because the two registers are equal, and broadcast is 0.
- R2: After a cycle with sel_ds high, a command write in a later cycle, with no other command write in between, loads cmd_data into dev_sel. The new value shows on the dev_sel port in the cycle after the write edge.
- R3: After a cycle with sel_pa high, the next command write loads cmd_data into page_addr when ff_en and chain_turn are both 1 and cmd_data is not 0xFFFF.
- R4: A page-address write that passes the ff_en and chain_turn gates but carries 0xFFFF leaves page_addr unchanged. It raises pa_err for exactly the cycle after the write edge. page_addr never holds 0xFFFF.
- R5: A page-address write made while ff_en is 0 leaves page_addr unchanged and does not raise pa_err.
- R6: A page-address write made while chain_turn is 0 leaves page_addr unchanged and does not raise pa_err.
- R7: selected is 1 whenever dev_sel equals page_addr.
- R8: When dev_sel is 0xFFFF, broadcast, selected and rd_restrict are all 1, and rd_en stays 0 even when rd_req is 1. Otherwise, rd_en equals rd_req while selected is 1.
- R9: sw_reset leaves page_addr and dev_sel unchanged and cancels an armed write. A command write after sw_reset, with no new strobe, changes neither register.
- R10: A command write with no select strobe before it changes neither register.
- R11: One strobe arms exactly one command write. A second command write after it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| sw_reset | input | 1 | Software reset pulse; cancels an armed write only |
| sel_pa | input | 1 | Strobe that arms a page-address write |
| sel_ds | input | 1 | Strobe that arms a device-select write |
| cmd_wr | input | 1 | Command-write cycle |
| cmd_data | input | 16 | Command-write data |
| ff_en | input | 1 | Full-flag function enabled |
| chain_turn | input | 1 | This device is the enabled one in the chain |
| rd_req | input | 1 | Data-read request |
| page_addr | output | 16 | Page-address register |
| dev_sel | output | 16 | Device-select register (read-back) |
| selected | output | 1 | Device is a target of host commands |
| broadcast | output | 1 | Device-select value is all ones |
| rd_restrict | output | 1 | Reads are blocked because of broadcast |
| rd_en | output | 1 | Gated data-read enable |
| pa_err | output | 1 | One-cycle pulse for a rejected all-ones page address |

## Verification
An armed-write state that is wrong shows one cycle after the next command write. A register either takes a value it should not take, or keeps a value it should have taken. This shows directly on page_addr or dev_sel. The match and broadcast outputs are combinational from the registers, so a bad comparison shows in the same cycle on selected, rd_restrict and rd_en. Every stimulus cycle is followed by a comparison against a reference model. A fault therefore surfaces within one clock of the write that exposes it.

// File: rtl/chain_sel_regs.sv
module chain_sel_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_reset,
  input  logic         sel_pa,
  input  logic         sel_ds,
  input  logic         cmd_wr,
  input  logic [W-1:0] cmd_data,
  input  logic         ff_en,
  input  logic         chain_turn,
  input  logic         rd_req,
  output logic [W-1:0] page_addr,
  output logic [W-1:0] dev_sel,
  output logic         selected,
  output logic         broadcast,
  output logic         rd_restrict,
  output logic         rd_en,
  output logic         pa_err
);
  localparam logic [W-1:0] ALL1 = '1;

  typedef enum logic [1:0] {T_NONE, T_PA, T_DS} tgt_t;
  tgt_t pend;

  logic pa_gate, pa_wr, ds_wr, pa_load, pa_bad;

  assign pa_gate = ff_en & chain_turn;
  assign pa_wr   = cmd_wr & (pend == T_PA);
  assign ds_wr   = cmd_wr & (pend == T_DS);
  assign pa_load = pa_wr & pa_gate & (cmd_data != ALL1);
  assign pa_bad  = pa_wr & pa_gate & (cmd_data == ALL1);

  // a new strobe arms for the following cycle; sw_reset disarms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= T_NONE;
    else if (sw_reset) pend <= T_NONE;
    else if (sel_pa)   pend <= T_PA;
    else if (sel_ds)   pend <= T_DS;
    else if (cmd_wr)   pend <= T_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_addr <= '0;
      dev_sel   <= '0;
      pa_err    <= 1'b0;
    end else begin
      if (pa_load) page_addr <= cmd_data;
      if (ds_wr)   dev_sel   <= cmd_data;
      pa_err <= pa_bad;
    end
  end

  assign broadcast   = (dev_sel == ALL1);
  assign selected    = broadcast | (dev_sel == page_addr);
  assign rd_restrict = broadcast;
  assign rd_en       = rd_req & selected & ~rd_restrict;

  p_legal_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_addr != ALL1);
  p_err_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pa_err |-> $stable(page_addr));
  p_ffdis_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_en |=> $stable(page_addr) && !pa_err);
  p_turn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_turn |=> $stable(page_addr) && !pa_err);
  p_bcast_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel == ALL1) |-> selected && !rd_en);
  p_swrst_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (cmd_wr |=> $stable(page_addr) && $stable(dev_sel)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(page_addr) && $stable(dev_sel));
endmodule

// File: tb/chain_sel_regs_tb.sv
module chain_sel_regs_tb;
  logic clk = 0, rst_n = 0;
  logic sw_reset = 0, sel_pa = 0, sel_ds = 0, cmd_wr = 0;
  logic [15:0] cmd_data = '0;
  logic ff_en = 1, chain_turn = 1, rd_req = 0;
  logic [15:0] page_addr, dev_sel;
  logic selected, broadcast, rd_restrict, rd_en, pa_err;

  always #5 clk = ~clk;

  chain_sel_regs u_dut (.clk, .rst_n, .sw_reset, .sel_pa, .sel_ds, .cmd_wr,
    .cmd_data, .ff_en, .chain_turn, .rd_req, .page_addr, .dev_sel,
    .selected, .broadcast, .rd_restrict, .rd_en, .pa_err);

  typedef struct {
    logic [15:0] pa, ds;
    logic sel, bc, rr, re, err;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  logic [15:0] m_pa = 0, m_ds = 0;
  int m_pend = 0;  // 0 none, 1 page, 2 device-select
  bit done = 0;

  function automatic exp_t mk(logic e, logic r, string t);
    exp_t x;
    x.pa = m_pa; x.ds = m_ds;
    x.bc = (m_ds == 16'hFFFF);
    x.sel = x.bc | (m_ds == m_pa);
    x.rr = x.bc;
    x.re = r & x.sel & ~x.rr;
    x.err = e;
    x.tag = t;
    return x;
  endfunction

  task automatic step(input logic spa, sds, wr, input logic [15:0] d,
                      input logic ff, ct, rr, sw, input string tag);
    logic e;
    @(negedge clk);
    sel_pa = spa; sel_ds = sds; cmd_wr = wr; cmd_data = d;
    ff_en = ff; chain_turn = ct; rd_req = rr; sw_reset = sw;
    @(posedge clk);
    e = wr && m_pend == 1 && ff && ct && d == 16'hFFFF;
    if (wr && m_pend == 2) m_ds = d;
    if (wr && m_pend == 1 && ff && ct && d != 16'hFFFF) m_pa = d;
    if (sw) m_pend = 0;
    else if (spa) m_pend = 1;
    else if (sds) m_pend = 2;
    else if (wr) m_pend = 0;
    #1 q.push_back(mk(e, rr, tag));
  endtask

  always @(posedge clk) begin
    #3;
    while (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (page_addr !== x.pa || dev_sel !== x.ds || selected !== x.sel ||
          broadcast !== x.bc || rd_restrict !== x.rr || rd_en !== x.re ||
          pa_err !== x.err) begin
        fails++;
        $display("FAIL %s: pa=%h ds=%h sel=%b bc=%b rr=%b re=%b err=%b expected pa=%h ds=%h sel=%b bc=%b rr=%b re=%b err=%b",
          x.tag, page_addr, dev_sel, selected, broadcast, rd_restrict, rd_en, pa_err,
          x.pa, x.ds, x.sel, x.bc, x.rr, x.re, x.err);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 checks++;  // R1 reset state
    if (page_addr !== 0 || dev_sel !== 0 || selected !== 1 || broadcast !== 0 || pa_err !== 0) begin
      fails++;
      $display("FAIL R1: pa=%h ds=%h sel=%b bc=%b expected pa=0000 ds=0000 sel=1 bc=0",
        page_addr, dev_sel, selected, broadcast);
    end
    @(negedge clk) rst_n = 1;
    step(0,0,0,16'h0,1,1,1,0,"R1");
    // R2: device-select load and read-back
    step(0,1,0,16'h0,1,1,0,0,"R2");
    step(0,0,1,16'h1234,1,1,0,0,"R2");
    step(0,0,0,16'h0,1,1,1,0,"R2");
    // R3 / R7: matching page address
    step(1,0,0,16'h0,1,1,0,0,"R3");
    step(0,0,1,16'h1234,1,1,0,0,"R3");
    step(0,0,0,16'h0,1,1,1,0,"R7");
    // R5: full flag disabled
    step(1,0,0,16'h0,0,1,0,0,"R5");
    step(0,0,1,16'h0055,0,1,0,0,"R5");
    step(1,0,0,16'h0,1,1,0,0,"R5");
    step(0,0,1,16'hFFFF,0,1,0,0,"R5");
    // R6: not this device's turn
    step(1,0,0,16'h0,1,0,0,0,"R6");
    step(0,0,1,16'h0077,1,0,0,0,"R6");
    // R4: all-ones page address rejected
    step(1,0,0,16'h0,1,1,0,0,"R4");
    step(0,0,1,16'hFFFF,1,1,0,0,"R4");
    step(0,0,0,16'h0,1,1,0,0,"R4");
    // R8: broadcast
    step(0,1,0,16'h0,1,1,0,0,"R8");
    step(0,0,1,16'hFFFF,1,1,1,0,"R8");
    step(0,0,0,16'h0,1,1,1,0,"R8");
    // R8: non-match then match with reads
    step(0,1,0,16'h0,1,1,1,0,"R8");
    step(0,0,1,16'h4321,1,1,1,0,"R8");
    step(0,0,0,16'h0,1,1,1,0,"R8");
    // R9: sw_reset disarms, keeps registers
    step(0,1,0,16'h0,1,1,0,0,"R9");
    step(0,0,0,16'h0,1,1,0,1,"R9");
    step(0,0,1,16'h1234,1,1,1,0,"R9");
    step(1,0,0,16'h0,1,1,0,0,"R9");
    step(0,0,0,16'h0,1,1,0,1,"R9");
    step(0,0,1,16'h4321,1,1,1,0,"R9");
    // R10: write without strobe
    step(0,0,1,16'hFFFF,1,1,0,0,"R10");
    step(0,0,1,16'h4321,1,1,1,0,"R10");
    // R11: one strobe, one write
    step(1,0,0,16'h0,1,1,0,0,"R11");
    step(0,0,1,16'h4321,1,1,1,0,"R11");
    step(0,0,1,16'h0999,1,1,1,0,"R11");
    step(0,1,0,16'h0,1,1,0,0,"R11");
    step(0,0,1,16'hABCD,1,1,0,0,"R11");
    step(0,0,1,16'h4321,1,1,1,0,"R11");
    step(0,0,0,16'h0,1,1,0,0,"R11");
    repeat (2) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule